// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

This block gathers edge-triggered interrupt sources, organised as several 32-bit source sets, and presents them to a processor on two request lines. A fixed map, built into the hardware, places a few sources in a high tier with priority levels 1 to 15. Every other source belongs to a low tier. Low-tier sources are masked one bit at a time through per-set enable registers. High-tier sources are gated one level at a time through a priority mask word in a control register. For the high tier, the block reports the winning level as a 4-bit vector.

Each source set has three registers: a sticky status register, an enable register and a write-one-to-clear register. A summary register shows which tier is pending and holds the current vector. A control register holds the global enable and the per-level mask. Software services the high line first. It reads the vector, clears the source, and the vector then drops to the next pending level. The map places the power-good rising and falling edges at level 15, the alarm at 14, the periodic timer at 13, the sound, telephony and codec DMA counters at 4, 3 and 2, and the two lowest I/O-port edge sources at 1.

Register addresses are `{kind[1:0], set[1:0]}`. The kinds are 0 status (read), 1 enable (read/write), 2 clear (write), and 3 special. Kind 3 with set 0 is the summary: bits[3:0] hold the vector, bit 8 is the high-tier pending flag and bit 9 is the low-tier pending flag. Kind 3 with set 1 is the control register: bit 0 is the global enable and bit p (1..15) unmasks level p. The high-tier positions, as (set, bit), are: (3,0) and (3,1) at level 15, (3,2) at 14, (3,3) at 13, (1,0) at 4, (1,1) at 3, (1,2) at 2, and (2,0) and (2,1) at 1. Source index = set*32 + bit.

Top module: `tier_irq_ctrl`

## Requirements
- R1: A rising edge on a source input sets its status bit one clock later. The bit stays set after the source returns low, until it is cleared.
- R2: Writing the clear register of a set clears each status bit whose data bit is 1. Status bits whose data bit is 0 are unchanged.
- R3: If a new edge and a clearing write reach the same bit in the same cycle, the bit stays set.
- R4: `irq_lo` rises when some low-tier status bit is set and its enable bit is 1. A pending low-tier bit whose enable is 0 does not raise it.
- R5: The vector is the highest level p such that control bit p is 1 and some source mapped to p is pending. `irq_hi` is high exactly when that vector is nonzero and the global enable is set.
- R6: The vector reads 0 when no unmasked high-tier source is pending. While any source of a shared level is still pending, that level stays in the vector.
- R7: With control bit 0 at 0, both request lines are low. Status bits keep capturing edges in this state.
- R8: High-tier sources never raise `irq_lo`, even when their enable bits are 1.
- R9: Summary bit 8 is 1 when any high-tier status bit is set, whether or not its level is masked. Summary bit 9 is 1 when any enabled low-tier status bit is set.
- R10: The request lines are registered. They change one cycle after the status or control change that causes them.
- R11: Reset clears all status bits, all enables, the priority mask, the global enable and both request lines.
- R12: The fixed level map matches the positions listed above. Clearing the periodic-timer bit (3,3) removes level 13 from the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NSETS*32 | Source lines; a rising edge raises a request |
| bus_addr | input | 4 | Register address {kind, set} |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_hi | output | 1 | High-tier request line |
| irq_lo | output | 1 | Low-tier request line |

## Verification
The bench drives an edge and a clearing write into the same bit in the same cycle. A design that gave the clear priority would lose that request. It checks that a masked level and a disabled low-tier bit leave the lines quiet, while the summary flags still show what is pending. A design that mixed up the two gating schemes would raise the wrong line. It clears one of two sources that share a level, which catches a vector that drops too early. It checks that the lines stay low for the first cycle after a capture, which catches a design that drives the request lines combinationally.

// File: rtl/tic_pkg.sv
// Shared constants and the fixed high-tier level map.
// Assumes 32-bit sets and at most 15 high-tier levels.
package tic_pkg;
    localparam int SET_W   = 32;
    localparam int LVL_W   = 4;
    localparam int NLVL    = 15;
    localparam logic [1:0] K_STAT = 2'd0;
    localparam logic [1:0] K_EN   = 2'd1;
    localparam logic [1:0] K_CLR  = 2'd2;
    localparam logic [1:0] K_SPEC = 2'd3;

    // Returns the high-tier level of (set, bit), 0 for low tier.
    function automatic logic [LVL_W-1:0] hi_level(int s, int b);
        logic [LVL_W-1:0] lv;
        lv = '0;
        case (s)
            1: case (b)
                   0: lv = 4'd4;
                   1: lv = 4'd3;
                   2: lv = 4'd2;
                   default: lv = '0;
               endcase
            2: case (b)
                   0, 1: lv = 4'd1;
                   default: lv = '0;
               endcase
            3: case (b)
                   0, 1: lv = 4'd15;
                   2: lv = 4'd14;
                   3: lv = 4'd13;
                   default: lv = '0;
               endcase
            default: lv = '0;
        endcase
        return lv;
    endfunction
endpackage

// File: rtl/tic_set_bank.sv
// One source set: rising-edge capture, sticky status with
// write-one-to-clear, and the per-bit enable register.
// Assumes sources are synchronous to clk; a new edge beats a clear.
module tic_set_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] enable
);
    logic [W-1:0] src_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr_mask;

    // Rising edges seen this cycle and bits this write clears.
    always_comb begin
        rise     = src & ~src_q;
        clr_mask = clr_we ? wdata : '0;
    end

    // Source history, sticky status and enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            status <= '0;
            enable <= '0;
        end else begin
            src_q  <= src;
            status <= (status & ~clr_mask) | rise;
            if (en_we) enable <= wdata;
        end
    end
endmodule

// File: rtl/tic_prio_enc.sv
// Splits status into tiers using the fixed map, resolves the
// highest unmasked high-tier level and the low-tier pending state.
// Assumes a purely combinational use; outputs are registered above.
module tic_prio_enc
    import tic_pkg::*;
#(
    parameter int NSETS = 4
) (
    input  logic [NSETS*SET_W-1:0] status,
    input  logic [NSETS*SET_W-1:0] enable,
    input  logic [NLVL:1]          mask,
    output logic [LVL_W-1:0]       vec,
    output logic                   hi_any,
    output logic                   lo_any
);
    logic [NLVL:1] lvl_pend;

    // Per-level pending bits and enabled low-tier summary.
    always_comb begin
        logic [LVL_W-1:0] lv;
        lvl_pend = '0;
        lo_any   = 1'b0;
        for (int s = 0; s < NSETS; s++) begin
            for (int b = 0; b < SET_W; b++) begin
                lv = hi_level(s, b);
                if (lv != '0) begin
                    if (status[s*SET_W+b]) lvl_pend[lv] = 1'b1;
                end else begin
                    lo_any = lo_any | (status[s*SET_W+b] & enable[s*SET_W+b]);
                end
            end
        end
        hi_any = |lvl_pend;
    end

    // Highest unmasked pending level wins; ascending scan keeps the last.
    always_comb begin
        vec = '0;
        for (int p = 1; p <= NLVL; p++) begin
            if (lvl_pend[p] && mask[p]) vec = LVL_W'(p);
        end
    end
endmodule

// File: rtl/tier_irq_ctrl.sv
// Two-tier interrupt controller top: register decode, control
// register, read mux and registered request lines.
// Assumes NSETS is a power of two and at least 2.
module tier_irq_ctrl
    import tic_pkg::*;
#(
    parameter int NSETS  = 4,
    parameter int SIDX_W = $clog2(NSETS),
    parameter int ADDR_W = SIDX_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSETS*SET_W-1:0] src_in,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic [SET_W-1:0]       bus_wdata,
    output logic [SET_W-1:0]       bus_rdata,
    output logic                   irq_hi,
    output logic                   irq_lo
);
    logic [1:0]             kind;
    logic [SIDX_W-1:0]      sidx;
    logic [NSETS*SET_W-1:0] stat_all;
    logic [NSETS*SET_W-1:0] en_all;
    logic                   ctl_gen;
    logic [NLVL:1]          ctl_mask;
    logic [LVL_W-1:0]       vec;
    logic                   hi_any;
    logic                   lo_any;
    logic                   any_clr;

    // Address split into register kind and set index.
    always_comb begin
        kind    = bus_addr[ADDR_W-1 -: 2];
        sidx    = bus_addr[SIDX_W-1:0];
        any_clr = bus_wr && (kind == K_CLR);
    end

    genvar g;
    generate
        for (g = 0; g < NSETS; g++) begin : g_set
            tic_set_bank #(.W(SET_W)) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .src    (src_in[g*SET_W +: SET_W]),
                .clr_we (any_clr && (sidx == SIDX_W'(g))),
                .en_we  (bus_wr && (kind == K_EN) && (sidx == SIDX_W'(g))),
                .wdata  (bus_wdata),
                .status (stat_all[g*SET_W +: SET_W]),
                .enable (en_all[g*SET_W +: SET_W])
            );
        end
    endgenerate

    tic_prio_enc #(.NSETS(NSETS)) u_enc (
        .status (stat_all),
        .enable (en_all),
        .mask   (ctl_mask),
        .vec    (vec),
        .hi_any (hi_any),
        .lo_any (lo_any)
    );

    // Control register: global enable and per-level mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_gen  <= 1'b0;
            ctl_mask <= '0;
        end else if (bus_wr && kind == K_SPEC && sidx == SIDX_W'(1)) begin
            ctl_gen  <= bus_wdata[0];
            ctl_mask <= bus_wdata[NLVL:1];
        end
    end

    // Registered request lines gated by the global enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_hi <= 1'b0;
            irq_lo <= 1'b0;
        end else begin
            irq_hi <= ctl_gen && (vec != '0);
            irq_lo <= ctl_gen && lo_any;
        end
    end

    // Read mux over status, enable, summary and control.
    always_comb begin
        bus_rdata = '0;
        case (kind)
            K_STAT: bus_rdata = stat_all[sidx*SET_W +: SET_W];
            K_EN:   bus_rdata = en_all[sidx*SET_W +: SET_W];
            K_SPEC: begin
                if (sidx == SIDX_W'(0)) begin
                    bus_rdata[LVL_W-1:0] = vec;
                    bus_rdata[8]         = hi_any;
                    bus_rdata[9]         = lo_any;
                end else if (sidx == SIDX_W'(1)) begin
                    bus_rdata[0]      = ctl_gen;
                    bus_rdata[NLVL:1] = ctl_mask;
                end
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tier_irq_chk.sv
// Assertion checker bound into tier_irq_ctrl.
// Assumes synchronous active-low reset held for several cycles.
module tier_irq_chk #(
    parameter int NSETS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq_hi,
    input logic                irq_lo,
    input logic                gen,
    input logic [15:1]         mask,
    input logic [3:0]          vec,
    input logic [NSETS*32-1:0] status,
    input logic                any_clr
);
    // R7: global enable low forces both lines low next cycle.
    a_r7_gen_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |=> (!irq_hi && !irq_lo));

    // R1: without a clear write no status bit falls.
    a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !any_clr |=> ((status & $past(status)) == $past(status)));

    // R5: a nonzero vector always names an unmasked level.
    a_r5_vec_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (vec != 4'd0) |-> mask[vec]);

    // R10: high line follows a nonzero vector of the previous cycle.
    a_r10_hi_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> $past(vec != 4'd0 && gen));

    // R11: reset leaves status empty and the lines quiet.
    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && !irq_hi && !irq_lo));
endmodule

bind tier_irq_ctrl tier_irq_chk #(.NSETS(NSETS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_hi  (irq_hi),
    .irq_lo  (irq_lo),
    .gen     (ctl_gen),
    .mask    (ctl_mask),
    .vec     (vec),
    .status  (stat_all),
    .any_clr (any_clr)
);

// File: tb/tier_irq_ctrl_test.sv
// Directed bench for tier_irq_ctrl; one task per scenario.
module tier_irq_ctrl_test;
    localparam int NS = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NS*32-1:0] src_in = '0;
    logic [3:0]     bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           irq_hi;
    logic           irq_lo;
    int             n_chk = 0;
    int             n_bad = 0;
    logic           done = 1'b0;

    tier_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_hi(irq_hi), .irq_lo(irq_lo)
    );

    always #4 clk = ~clk;

    function automatic logic [3:0] ad(int k, int s);
        return 4'(k * 4 + s);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Ends at the negedge after capture: status set, lines not yet updated.
    task automatic pulse(int idx);
        @(negedge clk);
        src_in[idx] = 1'b1;
        @(negedge clk);
        src_in[idx] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int s = 0; s < NS; s++) begin
            rd(ad(0, s), d); chk("R11 status", d, 0);
            rd(ad(1, s), d); chk("R11 enable", d, 0);
        end
        rd(ad(3, 1), d); chk("R11 control", d, 0);
        rd(ad(3, 0), d); chk("R11 summary", d, 0);
        chk("R11 lines", {30'd0, irq_hi, irq_lo}, 0);
    endtask

    task automatic t_low();
        logic [31:0] d;
        wr(ad(3, 1), 32'h1);
        wr(ad(1, 0), 32'h20);
        pulse(5);
        rd(ad(0, 0), d); chk("R1 status after source low", d, 32'h20);
        chk("R10 low line still 0", {31'd0, irq_lo}, 0);
        @(negedge clk);
        chk("R4 low line", {31'd0, irq_lo}, 1);
        chk("R8 hi line quiet", {31'd0, irq_hi}, 0);
        rd(ad(3, 0), d); chk("R9 summary low flag", d, 32'h200);
        wr(ad(2, 0), 32'hFFFF_FFDF);
        rd(ad(0, 0), d); chk("R2 zero bit kept", d, 32'h20);
        wr(ad(2, 0), 32'h20);
        rd(ad(0, 0), d); chk("R2 one bit cleared", d, 0);
        @(negedge clk);
        chk("R4 low line drops", {31'd0, irq_lo}, 0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        pulse(7);
        @(negedge clk); @(negedge clk);
        rd(ad(0, 0), d); chk("R1 disabled bit captured", d, 32'h80);
        chk("R4 disabled bit no line", {31'd0, irq_lo}, 0);
        wr(ad(2, 0), 32'h80);
    endtask

    task automatic t_high();
        logic [31:0] d;
        wr(ad(1, 3), 32'hF);
        wr(ad(3, 1), 32'h1 | (32'h1 << 13) | (32'h1 << 4));
        pulse(3*32 + 3);
        pulse(1*32 + 0);
        rd(ad(3, 0), d); chk("R5 vector 13 over 4", d, 32'h100 | 13);
        @(negedge clk);
        chk("R5 hi line", {31'd0, irq_hi}, 1);
        chk("R8 timer enable no low line", {31'd0, irq_lo}, 0);
        wr(ad(2, 3), 32'h8);
        rd(ad(3, 0), d); chk("R12 timer clear leaves 4", d, 32'h100 | 4);
        wr(ad(3, 1), 32'h1 | (32'h1 << 13));
        rd(ad(3, 0), d); chk("R9 masked level flag only", d, 32'h100);
        @(negedge clk);
        chk("R5 masked level no hi line", {31'd0, irq_hi}, 0);
        wr(ad(2, 1), 32'h1);
        wr(ad(1, 3), 32'h0);
    endtask

    task automatic t_shared();
        logic [31:0] d;
        wr(ad(3, 1), 32'h1 | (32'h1 << 1));
        pulse(2*32 + 0);
        pulse(2*32 + 1);
        rd(ad(3, 0), d); chk("R6 shared level vector", d, 32'h100 | 1);
        wr(ad(2, 2), 32'h1);
        rd(ad(3, 0), d); chk("R6 shared level held", d, 32'h100 | 1);
        wr(ad(2, 2), 32'h2);
        rd(ad(3, 0), d); chk("R6 vector zero", d, 0);
        @(negedge clk);
        chk("R6 hi line off", {31'd0, irq_hi}, 0);
    endtask

    task automatic t_table();
        logic [31:0] d;
        wr(ad(3, 1), 32'hFFFE | 32'h1);
        pulse(3*32 + 2);
        rd(ad(3, 0), d); chk("R12 alarm level 14", d, 32'h100 | 14);
        pulse(3*32 + 1);
        rd(ad(3, 0), d); chk("R12 power fall level 15", d, 32'h100 | 15);
        wr(ad(2, 3), 32'h6);
        pulse(1*32 + 2);
        rd(ad(3, 0), d); chk("R12 codec level 2", d, 32'h100 | 2);
        pulse(1*32 + 1);
        rd(ad(3, 0), d); chk("R12 telephony level 3", d, 32'h100 | 3);
        wr(ad(2, 1), 32'h6);
    endtask

    task automatic t_gen_off();
        logic [31:0] d;
        wr(ad(1, 0), 32'h1);
        wr(ad(3, 1), 32'hFFFE);
        pulse(0);
        pulse(3*32 + 0);
        rd(ad(0, 0), d); chk("R7 capture while off", d, 32'h1);
        rd(ad(3, 0), d); chk("R7 vector while off", d, 32'h300 | 15);
        @(negedge clk); @(negedge clk);
        chk("R7 lines low", {30'd0, irq_hi, irq_lo}, 0);
        wr(ad(3, 1), 32'hFFFF);
        @(negedge clk);
        chk("R7 lines on after enable", {30'd0, irq_hi, irq_lo}, 3);
        wr(ad(2, 0), 32'h1);
        wr(ad(2, 3), 32'h1);
    endtask

    task automatic t_race();
        logic [31:0] d;
        pulse(9);
        @(negedge clk);
        src_in[9] = 1'b1;
        bus_addr = ad(2, 0); bus_wdata = 32'h200; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; src_in[9] = 1'b0;
        rd(ad(0, 0), d); chk("R3 edge beats clear", d, 32'h200);
        wr(ad(2, 0), 32'h200);
        rd(ad(0, 0), d); chk("R2 later clear works", d, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_low();
        t_disabled();
        t_high();
        t_shared();
        t_table();
        t_gen_off();
        t_race();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule